// File: doc/BRIEF.md
# Sector ECC Correction Sequencer

This block runs the read-side repair of one 512-byte sector after a four-error-correcting syndrome engine has seen the sector's data. It holds the sector in a local byte buffer. A host fills and reads that buffer while the block is idle. The same host arms the engine for a new sector by writing a chip select into the engine control word. When told to start, the sequencer takes the ten stored check bytes. If every one of them is 0xFF, it treats the sector as never written and does no work. Otherwise it feeds eight 10-bit expected check values to the engine and reads back the syndrome.

A zero syndrome ends the run with nothing to fix. A non-zero syndrome makes the block launch error localisation and poll the engine status until the engine reports no error, too many errors, or a ready list of one to four error reports. Each report gives a raw location and an error byte. The location is mapped back to a byte index and the error byte is XORed into the buffer, but only when the index falls inside the data area. The run ends with a one-cycle done pulse, the number of bytes actually repaired, and flags for an uncorrectable sector or an engine that stayed busy too long.

Top module: `sector_ecc_corrector`

## Requirements
- R1: While idle, an `arm` pulse rewrites `eng_ctrl` so that bits 5:4 hold `arm_cs`, bit 12 is set and every other bit keeps its value, and `eng_ctrl_we` is high for exactly the following cycle.
- R2: If all ten check bytes equal 0xFF, the run ends with a zero count, without load strobes and without launching localisation.
- R3: The check bytes form an 80-bit little-endian word (byte 0 in bits 7:0). Expected value i is bits 10i+9:10i. The values are sent one per `eng_load_we` strobe in the order 7, 6, ..., 0.
- R4: After the loads, the four syndrome words are ORed and masked with 0x03FF03FF. A zero result ends the run with a zero count and no localisation.
- R5: A non-zero masked syndrome sets bit 13 of `eng_ctrl`, together with an `eng_ctrl_we` strobe, and polling of status bits 11:8 begins.
- R6: Status code 0 ends the run with a zero count. Code 1 ends it with `uncorrectable` set. Codes 2 and 3 mean the reports are ready. Any other code means busy.
- R7: A ready status gives 1 + status[17:16] errors. Errors 0 and 1 read `eng_addr0`/`eng_val0`, and errors 2 and 3 read `eng_addr1`/`eng_val1`. Even errors use bits 15:0 and odd errors use bits 31:16. The location is the low 10 bits of the half and the error byte is the low 8 bits.
- R8: The byte index is 519 minus the location. The error byte is XORed into the buffer only when the index lies in 0..511, and `corr_count` counts only the bytes that were written.
- R9: Corrections are applied one after another, so two reports that name the same byte both take effect (net XOR of both values).
- R10: `done` is high for one cycle per run. `corr_count`, `uncorrectable` and `timeout_err` keep their values until the next accepted start, and all outputs are zero after reset.
- R11: While a run is active, `start`, `arm` and host buffer writes have no effect.
- R12: If the status stays busy for POLL_LIMIT polls, the run ends with `timeout_err` set, a zero count and `uncorrectable` clear.
- R13: While idle, a host write stores `host_wdata` at `host_addr`, and `host_rdata` shows the byte at `host_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Arm the engine for a new sector (idle only) |
| arm_cs | input | 2 | Chip select written into control bits 5:4 |
| start | input | 1 | Begin the correction run (idle only) |
| chk_bytes | input | 80 | Ten stored check bytes, byte 0 in bits 7:0 |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 9 | Host buffer byte address |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Host buffer read data, one cycle latency |
| eng_ctrl | output | 32 | Engine control word |
| eng_ctrl_we | output | 1 | Control word write strobe |
| eng_load_we | output | 1 | Expected-value load strobe |
| eng_load_val | output | 10 | Expected check value being loaded |
| eng_syn0 | input | 32 | Syndrome word 0 |
| eng_syn1 | input | 32 | Syndrome word 1 |
| eng_syn2 | input | 32 | Syndrome word 2 |
| eng_syn3 | input | 32 | Syndrome word 3 |
| eng_status | input | 32 | Engine status word |
| eng_addr0 | input | 32 | Locations of errors 0 (low) and 1 (high) |
| eng_addr1 | input | 32 | Locations of errors 2 (low) and 3 (high) |
| eng_val0 | input | 32 | Error bytes of errors 0 (low) and 1 (high) |
| eng_val1 | input | 32 | Error bytes of errors 2 (low) and 3 (high) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| corr_count | output | 3 | Bytes repaired in the last run |
| uncorrectable | output | 1 | Engine reported five or more errors |
| timeout_err | output | 1 | Engine stayed busy past the poll limit |

## Verification
The buffer port is shared, so a host write can land in the same cycle as a correction write-back. The bench provokes this by holding a host write of 0x00 to the byte under repair during a whole run that corrects that byte twice. It judges the outcome by a full buffer readback against a reference model, which must show only the double XOR. In the same run a second start pulse arrives during the load phase; the check is that the load stream and the final result show no trace of it.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int CHK_BYTES = 10;
  localparam int CHK_VALS  = 8;
  localparam int VAL_W     = 10;
  localparam int SEL_W     = $clog2(CHK_VALS);
  localparam int WORD_W    = 32;

  localparam logic [WORD_W-1:0] SYN_MASK = 32'h03FF_03FF;
  localparam logic [WORD_W-1:0] CS_MASK  = 32'h0000_0030;
  localparam int                CS_LSB   = 4;
  localparam logic [WORD_W-1:0] EN_BIT   = 32'h0000_1000;
  localparam logic [WORD_W-1:0] LOC_BIT  = 32'h0000_2000;

  localparam logic [3:0] ST_CLEAN = 4'd0;
  localparam logic [3:0] ST_MANY  = 4'd1;
  localparam logic [3:0] ST_RDY_A = 4'd2;
  localparam logic [3:0] ST_RDY_B = 4'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_LOAD, S_SYNW, S_SYN, S_POLL, S_CADDR, S_CMOD
  } seq_state_t;
endpackage

// File: rtl/secc_unpack.sv
module secc_unpack
  import secc_pkg::*;
(
  input  logic [CHK_BYTES*8-1:0] chk,
  input  logic [SEL_W-1:0]       sel,
  output logic [VAL_W-1:0]       val,
  output logic                   erased
);
  logic [CHK_BYTES-1:0] byte_ff;

  for (genvar b = 0; b < CHK_BYTES; b++) begin : g_ff
    assign byte_ff[b] = &chk[8*b +: 8];
  end
  assign erased = &byte_ff;

  always_comb begin
    val = '0;
    for (int i = 0; i < CHK_VALS; i++) begin
      if (sel == SEL_W'(i)) val = chk[VAL_W*i +: VAL_W];
    end
  end
endmodule

// File: rtl/secc_errpick.sv
module secc_errpick
  import secc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int AW           = $clog2(SECTOR_BYTES)
) (
  input  logic [WORD_W-1:0] addr_lo,
  input  logic [WORD_W-1:0] addr_hi,
  input  logic [WORD_W-1:0] val_lo,
  input  logic [WORD_W-1:0] val_hi,
  input  logic [1:0]        sel,
  output logic [AW-1:0]     idx,
  output logic [7:0]        xval,
  output logic              in_range
);
  localparam int BIAS = SECTOR_BYTES + 7;

  logic [WORD_W-1:0] aw, vw;
  logic [15:0]       ah, vh;
  logic              unused_bits;
  int                diff;

  always_comb begin
    aw       = sel[1] ? addr_hi : addr_lo;
    vw       = sel[1] ? val_hi  : val_lo;
    ah       = sel[0] ? aw[31:16] : aw[15:0];
    vh       = sel[0] ? vw[31:16] : vw[15:0];
    diff     = BIAS - int'(ah[VAL_W-1:0]);
    in_range = (diff >= 0) && (diff < SECTOR_BYTES);
    idx      = AW'(diff);
    xval     = vh[7:0];
  end

  assign unused_bits = ^{ah[15:VAL_W], vh[15:8]};
endmodule

// File: rtl/secc_secbuf.sv
module secc_secbuf #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/sector_ecc_corrector.sv
module sector_ecc_corrector
  import secc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int POLL_LIMIT   = 4096
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            arm,
  input  logic [1:0]                      arm_cs,
  input  logic                            start,
  input  logic [CHK_BYTES*8-1:0]          chk_bytes,
  input  logic                            host_we,
  input  logic [$clog2(SECTOR_BYTES)-1:0] host_addr,
  input  logic [7:0]                      host_wdata,
  output logic [7:0]                      host_rdata,
  output logic [WORD_W-1:0]               eng_ctrl,
  output logic                            eng_ctrl_we,
  output logic                            eng_load_we,
  output logic [VAL_W-1:0]                eng_load_val,
  input  logic [WORD_W-1:0]               eng_syn0,
  input  logic [WORD_W-1:0]               eng_syn1,
  input  logic [WORD_W-1:0]               eng_syn2,
  input  logic [WORD_W-1:0]               eng_syn3,
  input  logic [WORD_W-1:0]               eng_status,
  input  logic [WORD_W-1:0]               eng_addr0,
  input  logic [WORD_W-1:0]               eng_addr1,
  input  logic [WORD_W-1:0]               eng_val0,
  input  logic [WORD_W-1:0]               eng_val1,
  output logic                            busy,
  output logic                            done,
  output logic [2:0]                      corr_count,
  output logic                            uncorrectable,
  output logic                            timeout_err
);
  localparam int AW = $clog2(SECTOR_BYTES);
  localparam int TW = $clog2(POLL_LIMIT + 1);

  seq_state_t             state;
  logic [CHK_BYTES*8-1:0] chk_q;
  logic [SEL_W-1:0]       vsel;
  logic [1:0]             k;
  logic [2:0]             nerr, cnt;
  logic [TW-1:0]          tmr;
  logic [AW-1:0]          fix_idx, pick_idx, ram_addr;
  logic [7:0]             fix_val, pick_val, ram_wdata, ram_rdata;
  logic                   pick_ok, erased, ram_we, syn_zero, last_err;
  logic [VAL_W-1:0]       cur_val;
  logic [3:0]             st_code;
  logic                   unused_status;

  secc_unpack u_unpack (
    .chk(chk_q), .sel(vsel), .val(cur_val), .erased(erased)
  );

  secc_errpick #(.SECTOR_BYTES(SECTOR_BYTES), .AW(AW)) u_pick (
    .addr_lo(eng_addr0), .addr_hi(eng_addr1), .val_lo(eng_val0), .val_hi(eng_val1),
    .sel(k), .idx(pick_idx), .xval(pick_val), .in_range(pick_ok)
  );

  secc_secbuf #(.DEPTH(SECTOR_BYTES), .AW(AW)) u_buf (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign st_code       = eng_status[11:8];
  assign unused_status = ^{eng_status[31:18], eng_status[15:12], eng_status[7:0]};
  assign syn_zero      = ((eng_syn0 | eng_syn1 | eng_syn2 | eng_syn3) & SYN_MASK) == '0;
  assign last_err      = ({1'b0, k} == (nerr - 3'd1));
  assign busy          = (state != S_IDLE);

  // Buffer port: host owns it when idle, the corrector owns it otherwise.
  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = fix_idx;
    ram_wdata = ram_rdata ^ fix_val;
    case (state)
      S_IDLE: begin
        ram_we    = host_we;
        ram_addr  = host_addr;
        ram_wdata = host_wdata;
      end
      S_CADDR: ram_addr = pick_idx;
      S_CMOD:  ram_we   = 1'b1;
      default: ;
    endcase
  end
  assign host_rdata = ram_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      chk_q         <= '0;
      vsel          <= '0;
      k             <= '0;
      nerr          <= '0;
      cnt           <= '0;
      tmr           <= '0;
      fix_idx       <= '0;
      fix_val       <= '0;
      eng_ctrl      <= '0;
      eng_ctrl_we   <= 1'b0;
      eng_load_we   <= 1'b0;
      eng_load_val  <= '0;
      done          <= 1'b0;
      corr_count    <= '0;
      uncorrectable <= 1'b0;
      timeout_err   <= 1'b0;
    end else begin
      eng_ctrl_we <= 1'b0;
      eng_load_we <= 1'b0;
      done        <= 1'b0;
      case (state)
        S_IDLE: begin
          if (arm) begin
            eng_ctrl    <= (eng_ctrl & ~CS_MASK) | ({30'd0, arm_cs} << CS_LSB) | EN_BIT;
            eng_ctrl_we <= 1'b1;
          end
          if (start) begin
            chk_q         <= chk_bytes;
            cnt           <= '0;
            corr_count    <= '0;
            uncorrectable <= 1'b0;
            timeout_err   <= 1'b0;
            state         <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (erased) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            vsel  <= SEL_W'(CHK_VALS - 1);
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          eng_load_we  <= 1'b1;
          eng_load_val <= cur_val;
          if (vsel == '0) state <= S_SYNW;
          else            vsel  <= vsel - 1'b1;
        end
        S_SYNW: state <= S_SYN;
        S_SYN: begin
          if (syn_zero) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            eng_ctrl    <= eng_ctrl | LOC_BIT;
            eng_ctrl_we <= 1'b1;
            tmr         <= '0;
            state       <= S_POLL;
          end
        end
        S_POLL: begin
          case (st_code)
            ST_CLEAN: begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
            ST_MANY: begin
              uncorrectable <= 1'b1;
              done          <= 1'b1;
              state         <= S_IDLE;
            end
            ST_RDY_A, ST_RDY_B: begin
              nerr  <= 3'd1 + {1'b0, eng_status[17:16]};
              k     <= '0;
              state <= S_CADDR;
            end
            default: begin
              if (tmr == TW'(POLL_LIMIT - 1)) begin
                timeout_err <= 1'b1;
                done        <= 1'b1;
                state       <= S_IDLE;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          endcase
        end
        S_CADDR: begin
          if (pick_ok) begin
            fix_idx <= pick_idx;
            fix_val <= pick_val;
            state   <= S_CMOD;
          end else if (last_err) begin
            corr_count <= cnt;
            done       <= 1'b1;
            state      <= S_IDLE;
          end else begin
            k <= k + 2'd1;
          end
        end
        S_CMOD: begin
          cnt <= cnt + 3'd1;
          if (last_err) begin
            corr_count <= cnt + 3'd1;
            done       <= 1'b1;
            state      <= S_IDLE;
          end else begin
            k     <= k + 2'd1;
            state <= S_CADDR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: the end-of-run pulse lasts one cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: never more repairs than reports
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (corr_count <= 3'd4));
  // R6: the uncorrectable flag only rises with the end of a run
  assert_uncorr_at_done_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(uncorrectable) |-> done);
  // R5: the localisation bit only appears through a control write
  assert_locate_strobed_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_ctrl[13]) |-> eng_ctrl_we);
  // R3: load strobes only inside a run
  assert_load_in_run_R3: assert property (@(posedge clk) disable iff (rst)
    eng_load_we |-> busy);
  // R12: a timeout reports nothing else
  assert_timeout_alone_R12: assert property (@(posedge clk) disable iff (rst)
    (done && timeout_err) |-> (corr_count == 3'd0 && !uncorrectable));
  // R11: the host port cannot write the buffer during a run
  assert_host_blocked_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && ram_we) |-> (state == S_CMOD));
endmodule

// File: tb/sim_sector_ecc_corrector.sv
module sim_sector_ecc_corrector;
  localparam int SB = 512;
  localparam int PL = 40;

  logic        clk = 1'b0;
  logic        rst;
  logic        arm, start, host_we;
  logic [1:0]  arm_cs;
  logic [79:0] chk_bytes;
  logic [8:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic [31:0] eng_ctrl;
  logic        eng_ctrl_we, eng_load_we;
  logic [9:0]  eng_load_val;
  logic [31:0] eng_syn0, eng_syn1, eng_syn2, eng_syn3, eng_status;
  logic [31:0] eng_addr0, eng_addr1, eng_val0, eng_val1;
  logic        busy, done, uncorrectable, timeout_err;
  logic [2:0]  corr_count;

  always #10 clk = ~clk;

  sector_ecc_corrector #(.SECTOR_BYTES(SB), .POLL_LIMIT(PL)) u0 (.*);

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] ref_mem [SB];
  int lq[$];
  bit   loc_seen;
  int   cd, busy_len;
  logic [31:0] final_st, ctrl_exp;
  logic [3:0]  busy_code;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Engine model and load-stream comparison on every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (eng_load_we) begin
        if (lq.size() == 0) check(1'b0, "R3", "unexpected load", eng_load_val, 0);
        else begin
          int e;
          e = lq.pop_front();
          check(eng_load_val == 10'(e), "R3", "load value", eng_load_val, e);
        end
      end
      if (busy && eng_ctrl_we && eng_ctrl[13] && !loc_seen) begin
        loc_seen = 1'b1;
        cd = busy_len;
        ctrl_exp = ctrl_exp | 32'h2000;
      end else if (loc_seen && cd > 0) cd--;
      if (loc_seen && cd == 0) eng_status = final_st;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic read_byte(input int a, output logic [7:0] d);
    @(negedge clk);
    host_addr = 9'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic compare_all(input string req);
    int bad = -1;
    logic [7:0] d, e;
    for (int i = 0; i < SB; i++) begin
      logic [7:0] r;
      read_byte(i, r);
      if (bad < 0 && r !== ref_mem[i]) begin bad = i; d = r; e = ref_mem[i]; end
    end
    if (bad < 0) check(1'b1, req, "buffer", 0, 0);
    else check(1'b0, req, $sformatf("buffer byte %0d", bad), d, e);
  endtask

  // Behavioural expectation of the repair step from the report words
  task automatic expect_fix(input int n, output int c);
    c = 0;
    for (int e = 0; e < n; e++) begin
      logic [31:0] aw, vw;
      int raw, bi;
      aw  = (e > 1) ? eng_addr1 : eng_addr0;
      vw  = (e > 1) ? eng_val1  : eng_val0;
      raw = (e % 2 == 1) ? int'(aw[25:16]) : int'(aw[9:0]);
      bi  = 519 - raw;
      if (bi >= 0 && bi < SB) begin
        ref_mem[bi] = ref_mem[bi] ^ ((e % 2 == 1) ? vw[23:16] : vw[7:0]);
        c++;
      end
    end
  endtask

  task automatic do_arm(input logic [1:0] cs);
    @(negedge clk);
    arm = 1'b1; arm_cs = cs;
    @(negedge clk);
    arm = 1'b0;
    ctrl_exp = (ctrl_exp & ~32'h30) | (32'(cs) << 4) | 32'h1000;
    check(eng_ctrl_we == 1'b1, "R1", "ctrl strobe", eng_ctrl_we, 1);
    check(eng_ctrl == ctrl_exp, "R1", "ctrl word", eng_ctrl, ctrl_exp);
    @(negedge clk);
    check(eng_ctrl_we == 1'b0, "R1", "ctrl strobe width", eng_ctrl_we, 0);
  endtask

  task automatic run_case(input logic [79:0] cb, input bit exp_loads, input bit exp_loc,
                          input int e_cnt, input bit e_unc, input bit e_tmo,
                          input bit jam, input int jam_a, input string req);
    bit got = 1'b0;
    loc_seen = 1'b0;
    cd = 0;
    eng_status = 32'h0003_0000 | (32'(busy_code) << 8);
    if (exp_loads)
      for (int i = 7; i >= 0; i--) lq.push_back(int'(cb[10*i +: 10]));
    @(negedge clk);
    start = 1'b1; chk_bytes = cb;
    @(negedge clk);
    start = 1'b0;
    if (jam) begin host_we = 1'b1; host_addr = 9'(jam_a); host_wdata = 8'h00; end
    for (int n = 0; n < 3000 && !got; n++) begin
      if (done) got = 1'b1;
      else begin
        start = (jam && n == 4);
        @(negedge clk);
      end
    end
    start = 1'b0;
    host_we = 1'b0;
    check(got, req, "done seen", got, 1);
    check(corr_count == 3'(e_cnt), req, "corr_count", corr_count, e_cnt);
    check(uncorrectable == e_unc, req, "uncorrectable", uncorrectable, e_unc);
    check(timeout_err == e_tmo, req, "timeout_err", timeout_err, e_tmo);
    check(lq.size() == 0, "R3", "loads missing", lq.size(), 0);
    check(loc_seen == exp_loc, req, "localisation launch", loc_seen, exp_loc);
    lq.delete();
    repeat (3) @(negedge clk);
    check(!done && !busy && corr_count == 3'(e_cnt) && uncorrectable == e_unc
          && timeout_err == e_tmo, "R10", "held result", {done, busy, corr_count}, e_cnt);
  endtask

  initial begin
    int c;
    logic [7:0] d;
    rst = 1'b1; arm = 1'b0; arm_cs = '0; start = 1'b0; chk_bytes = '0;
    host_we = 1'b0; host_addr = '0; host_wdata = '0;
    eng_syn0 = '0; eng_syn1 = '0; eng_syn2 = '0; eng_syn3 = '0;
    eng_status = '0; eng_addr0 = '0; eng_addr1 = '0; eng_val0 = '0; eng_val1 = '0;
    loc_seen = 1'b0; cd = 0; busy_len = 0; final_st = '0; ctrl_exp = '0; busy_code = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && eng_ctrl == 0 && corr_count == 0 && !uncorrectable && !timeout_err,
          "R10", "reset state", {busy, done, corr_count}, 0);

    // R13: host fill and readback
    for (int i = 0; i < SB; i++) begin
      @(negedge clk);
      ref_mem[i] = 8'((i * 37 + 11) % 256);
      host_we = 1'b1; host_addr = 9'(i); host_wdata = ref_mem[i];
    end
    @(negedge clk);
    host_we = 1'b0;
    read_byte(300, d);
    check(d == ref_mem[300], "R13", "host readback", d, ref_mem[300]);

    // R1: arm twice, chip select field replaced
    do_arm(2'd2);
    do_arm(2'd1);

    // R2: erased sector
    run_case({80{1'b1}}, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, "R2");

    // R4: syndrome non-zero only outside the mask
    eng_syn0 = 32'hFC00_FC00; eng_syn1 = 32'hFC00_FC00;
    eng_syn2 = 32'hFC00_0000; eng_syn3 = 32'h0000_FC00;
    run_case({8'hFE, {72{1'b1}}}, 1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 0, "R4");

    // R6: status code 0 after three busy polls
    eng_syn0 = 32'h0000_0001;
    busy_len = 3; final_st = 32'h0000_0000;
    run_case(80'h0123_4567_89AB_CDEF_0123, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0, 0, "R6");

    // R6: five or more errors
    final_st = 32'h0002_0100;
    run_case(80'hA5A5_5A5A_1234_8765_0F0F, 1'b1, 1'b1, 0, 1'b1, 1'b0, 1'b0, 0, "R6");

    // R7 / R8: four reports, one outside the data area
    eng_syn0 = '0; eng_syn2 = 32'h0100_0000;
    eng_addr0 = 32'hFC08_FE07; eng_addr1 = 32'h01A3_0004;
    eng_val0  = 32'h00C3_015A; eng_val1  = 32'h0024_00FF;
    final_st = 32'h0003_0200; busy_len = 0;
    expect_fix(4, c);
    check(c == 3, "R8", "model count", c, 3);
    run_case(80'h0000_1111_2222_3333_4444, 1'b1, 1'b1, c, 1'b0, 1'b0, 1'b0, 0, "R7");
    compare_all("R8");

    // R9 / R11: same byte twice, host write and restart jammed during the run
    eng_addr0 = 32'h013F_013F; eng_addr1 = 32'h0000_0000;
    eng_val0  = 32'h003C_000F; eng_val1  = 32'h0000_0000;
    final_st = 32'h0001_0300; busy_len = 2;
    expect_fix(2, c);
    run_case(80'hFFFF_0000_FFFF_0000_FFFF, 1'b1, 1'b1, c, 1'b0, 1'b0, 1'b1, 200, "R11");
    compare_all("R9");

    // R8: single report beyond the data area, busy code other than 0xF
    busy_code = 4'h5;
    eng_addr0 = 32'h0000_03E8; eng_val0 = 32'h0000_0077;
    final_st = 32'h0000_0200; busy_len = 10;
    expect_fix(1, c);
    run_case(80'h1357_9BDF_2468_ACE0_1122, 1'b1, 1'b1, c, 1'b0, 1'b0, 1'b0, 0, "R8");
    compare_all("R8");

    // R12: engine never leaves busy
    busy_len = 1000000;
    run_case(80'h0000_0000_0000_0000_0001, 1'b1, 1'b1, 0, 1'b0, 1'b1, 1'b0, 0, "R12");

    // R1: arm after localisation keeps bit 13
    do_arm(2'd3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule